// File: doc/BRIEF.md
# Combined Four-Lane Pseudo-Random Word Generator

This block delivers a fresh 32-bit pseudo-random word on every clock in which it is told to advance. It holds four state words and steps all of them together. Two are multiply-with-carry lanes with a 16-bit lag. One is a three-shift xorshift lane. The last is a linear congruential lane. Each step mixes the freshly updated lane values into a single output word. The combined sequence repeats only after roughly 2^123 steps. The output is meant to feed a converter that turns integers into unit-interval floats.

After reset the lanes hold fixed default seeds, so the sequence can be reproduced. A load strobe can replace all four seeds at once. A zero xorshift seed is swapped for its default, because an all-zero xorshift state never leaves zero. Every multiplier, increment, shift amount and default seed is a parameter.

Top module: `mixgen_rng`

## Requirements
- R1: While `rst` is high at a rising edge, the lanes take their defaults (first MWC lane 362436069, second MWC lane 521288629, xorshift 123456789, congruential 380116160), and `rnd_out` and `rnd_valid` go to 0. The first step after reset yields the first word of the default sequence.
- R2: On each step the first MWC lane becomes 36969 times its low 16 bits plus its high 16 bits. The second MWC lane does the same with multiplier 18000.
- R3: On each step the xorshift lane x becomes x^(x<<13), then that result t becomes t^(t>>17), then that result u becomes u^(u<<5).
- R4: On each step the congruential lane c becomes 69069*c + 1234567, modulo 2^32.
- R5: A step sets `rnd_out` to ((((z<<16)+w) ^ c) + x) mod 2^32. Here z, w, x and c are the lane values after that step's update. The word is visible from the rising edge that performs the step.
- R6: In a cycle with `step_en` and `seed_load` both low, the four lanes and `rnd_out` keep their values. The next step therefore continues the sequence where it stopped.
- R7: `rnd_valid` is 1 for exactly the cycle after each step edge. It is 0 after any edge without a step.
- R8: A rising edge with `seed_load` high loads `seed_z`, `seed_w`, `seed_x` and `seed_c` into the lanes. It takes priority over `step_en`, performs no step, leaves `rnd_out` unchanged and drives `rnd_valid` to 0.
- R9: A load with `seed_x` equal to 0 puts 123456789 into the xorshift lane instead. The xorshift lane is never zero.
- R10: From the default seeds, the first 4096 words match the recurrences of R2 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance all lanes by one step this edge |
| seed_load | input | 1 | Load the four seed words this edge |
| seed_z | input | 32 | Seed for the first MWC lane |
| seed_w | input | 32 | Seed for the second MWC lane |
| seed_x | input | 32 | Seed for the xorshift lane (0 means default) |
| seed_c | input | 32 | Seed for the congruential lane |
| rnd_out | output | 32 | Latest mixed random word |
| rnd_valid | output | 1 | High for one cycle after each step |

## Verification
The bench builds the block with its default parameters: the fixed multipliers, the 13/17/5 shift triple and the default seeds. These make a 4096-word stretch of the default sequence directly comparable with an independent software model. Loading zero into both MWC lanes keeps that half of the mix at zero, which exposes the xorshift and congruential lanes on their own. Further loads reach the zero-seed substitution, load-versus-step priority, and the hold-then-resume behaviour.

// File: rtl/mixgen_pkg.sv
`timescale 1ns/1ps
package mixgen_pkg;

  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;

  typedef logic [WORD_W-1:0] word_t;

  // multiply-with-carry: multiplier * low half + high half
  function automatic word_t mwc_next(input word_t s, input word_t mult);
    word_t lo;
    word_t hi;
    lo = word_t'(s[HALF_W-1:0]);
    hi = word_t'(s[WORD_W-1:HALF_W]);
    return (lo * mult) + hi;
  endfunction

  // three-stage xorshift, each stage feeding the next
  function automatic word_t xs_next(input word_t s, input int unsigned a,
                                    input int unsigned b, input int unsigned c);
    word_t t;
    t = s ^ (s << a);
    t = t ^ (t >> b);
    t = t ^ (t << c);
    return t;
  endfunction

  // linear congruential step modulo 2^WORD_W
  function automatic word_t lcg_next(input word_t s, input word_t mult, input word_t inc);
    return (s * mult) + inc;
  endfunction

  // join the two multiply-with-carry lanes
  function automatic word_t mwc_join(input word_t z, input word_t w);
    return (z << HALF_W) + w;
  endfunction

  // final mix of all four freshly updated lanes
  function automatic word_t mix_word(input word_t z, input word_t w,
                                     input word_t x, input word_t c);
    return (mwc_join(z, w) ^ c) + x;
  endfunction

endpackage

// File: rtl/mwc_lane.sv
`timescale 1ns/1ps
module mwc_lane
  import mixgen_pkg::*;
#(
  parameter word_t MULT = 32'd36969,
  parameter word_t SEED = 32'd362436069
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  input  logic  load,
  input  word_t load_val,
  output word_t state_q,
  output word_t state_nxt
);

  assign state_nxt = mwc_next(state_q, MULT);

  always_ff @(posedge clk) begin
    if (rst)       state_q <= SEED;
    else if (load) state_q <= load_val;
    else if (adv)  state_q <= state_nxt;
  end

endmodule

// File: rtl/xs_lane.sv
`timescale 1ns/1ps
module xs_lane
  import mixgen_pkg::*;
#(
  parameter int unsigned SH_A       = 13,
  parameter int unsigned SH_B       = 17,
  parameter int unsigned SH_C       = 5,
  parameter word_t       SEED       = 32'd123456789,
  parameter bit          ZERO_GUARD = 1'b1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  input  logic  load,
  input  word_t load_val,
  output word_t state_q,
  output word_t state_nxt
);

  word_t load_fix;

  generate
    if (ZERO_GUARD) begin : g_guard
      assign load_fix = (load_val == '0) ? SEED : load_val;
    end else begin : g_plain
      assign load_fix = load_val;
    end
  endgenerate

  assign state_nxt = xs_next(state_q, SH_A, SH_B, SH_C);

  always_ff @(posedge clk) begin
    if (rst)       state_q <= SEED;
    else if (load) state_q <= load_fix;
    else if (adv)  state_q <= state_nxt;
  end

endmodule

// File: rtl/lcg_lane.sv
`timescale 1ns/1ps
module lcg_lane
  import mixgen_pkg::*;
#(
  parameter word_t MULT = 32'd69069,
  parameter word_t INC  = 32'd1234567,
  parameter word_t SEED = 32'd380116160
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  adv,
  input  logic  load,
  input  word_t load_val,
  output word_t state_q,
  output word_t state_nxt
);

  assign state_nxt = lcg_next(state_q, MULT, INC);

  always_ff @(posedge clk) begin
    if (rst)       state_q <= SEED;
    else if (load) state_q <= load_val;
    else if (adv)  state_q <= state_nxt;
  end

endmodule

// File: rtl/mix_stage.sv
`timescale 1ns/1ps
module mix_stage
  import mixgen_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  fire,
  input  word_t z_nxt,
  input  word_t w_nxt,
  input  word_t x_nxt,
  input  word_t c_nxt,
  output word_t word_q,
  output logic  valid_q
);

  word_t mixed;

  assign mixed = mix_word(z_nxt, w_nxt, x_nxt, c_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= fire;
      if (fire) word_q <= mixed;
    end
  end

endmodule

// File: rtl/mixgen_rng.sv
`timescale 1ns/1ps
module mixgen_rng
  import mixgen_pkg::*;
#(
  parameter word_t       Z_MULT  = 32'd36969,
  parameter word_t       W_MULT  = 32'd18000,
  parameter int unsigned XS_A    = 13,
  parameter int unsigned XS_B    = 17,
  parameter int unsigned XS_C    = 5,
  parameter word_t       C_MULT  = 32'd69069,
  parameter word_t       C_INC   = 32'd1234567,
  parameter word_t       Z_SEED  = 32'd362436069,
  parameter word_t       W_SEED  = 32'd521288629,
  parameter word_t       XS_SEED = 32'd123456789,
  parameter word_t       C_SEED  = 32'd380116160
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              seed_load,
  input  logic [WORD_W-1:0] seed_z,
  input  logic [WORD_W-1:0] seed_w,
  input  logic [WORD_W-1:0] seed_x,
  input  logic [WORD_W-1:0] seed_c,
  output logic [WORD_W-1:0] rnd_out,
  output logic              rnd_valid
);

  // named internal events
  logic  step_fire;
  logic  load_fire;
  word_t z_q, w_q, x_q, c_q;
  word_t z_nxt, w_nxt, x_nxt, c_nxt;

  assign load_fire = seed_load;
  assign step_fire = step_en & ~seed_load;

  mwc_lane #(.MULT(Z_MULT), .SEED(Z_SEED)) u_lane_z (
    .clk(clk), .rst(rst), .adv(step_fire), .load(load_fire),
    .load_val(seed_z), .state_q(z_q), .state_nxt(z_nxt));

  mwc_lane #(.MULT(W_MULT), .SEED(W_SEED)) u_lane_w (
    .clk(clk), .rst(rst), .adv(step_fire), .load(load_fire),
    .load_val(seed_w), .state_q(w_q), .state_nxt(w_nxt));

  xs_lane #(.SH_A(XS_A), .SH_B(XS_B), .SH_C(XS_C), .SEED(XS_SEED), .ZERO_GUARD(1'b1)) u_lane_x (
    .clk(clk), .rst(rst), .adv(step_fire), .load(load_fire),
    .load_val(seed_x), .state_q(x_q), .state_nxt(x_nxt));

  lcg_lane #(.MULT(C_MULT), .INC(C_INC), .SEED(C_SEED)) u_lane_c (
    .clk(clk), .rst(rst), .adv(step_fire), .load(load_fire),
    .load_val(seed_c), .state_q(c_q), .state_nxt(c_nxt));

  mix_stage u_mix (
    .clk(clk), .rst(rst), .fire(step_fire),
    .z_nxt(z_nxt), .w_nxt(w_nxt), .x_nxt(x_nxt), .c_nxt(c_nxt),
    .word_q(rnd_out), .valid_q(rnd_valid));

endmodule

// File: rtl/mixgen_rng_chk.sv
`timescale 1ns/1ps
module mixgen_rng_chk
  import mixgen_pkg::*;
#(
  parameter word_t XS_SEED = 32'd123456789
) (
  input logic  clk,
  input logic  rst,
  input logic  step_en,
  input logic  seed_load,
  input word_t seed_x,
  input word_t rnd_out,
  input logic  rnd_valid,
  input logic  step_fire,
  input logic  load_fire,
  input word_t z_q,
  input word_t w_q,
  input word_t x_q,
  input word_t c_q
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!rnd_valid && rnd_out == '0));

  // R7
  valid_after_step_chk: assert property (@(posedge clk) disable iff (rst)
    step_fire |=> rnd_valid);

  // R7
  no_valid_without_step_chk: assert property (@(posedge clk) disable iff (rst)
    !step_fire |=> !rnd_valid);

  // R6
  idle_hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !seed_load) |=> ($stable(z_q) && $stable(w_q) && $stable(x_q) && $stable(c_q)));

  // R6
  idle_hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !seed_load) |=> $stable(rnd_out));

  // R8
  load_over_step_chk: assert property (@(posedge clk) disable iff (rst)
    (seed_load && step_en) |=> (!rnd_valid && $stable(rnd_out)));

  // R8
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    (load_fire && seed_x != '0) |=> (x_q == $past(seed_x)));

  // R9
  zero_seed_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (load_fire && seed_x == '0) |=> (x_q == XS_SEED));

  // R9
  xs_nonzero_chk: assert property (@(posedge clk) disable iff (rst) x_q != '0);

endmodule

bind mixgen_rng mixgen_rng_chk #(.XS_SEED(XS_SEED)) u_chk (
  .clk(clk), .rst(rst), .step_en(step_en), .seed_load(seed_load),
  .seed_x(seed_x), .rnd_out(rnd_out), .rnd_valid(rnd_valid),
  .step_fire(step_fire), .load_fire(load_fire),
  .z_q(z_q), .w_q(w_q), .x_q(x_q), .c_q(c_q));

// File: tb/tb_mixgen_rng.sv
`timescale 1ns/1ps
module tb_mixgen_rng;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_en = 1'b0;
  logic        seed_load = 1'b0;
  logic [31:0] seed_z = '0, seed_w = '0, seed_x = '0, seed_c = '0;
  logic [31:0] rnd_out;
  logic        rnd_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model state
  logic [31:0] mz, mw, mx, mc, last_exp;

  always #10 clk = ~clk;  // 50 MHz

  mixgen_rng dut (
    .clk(clk), .rst(rst), .step_en(step_en), .seed_load(seed_load),
    .seed_z(seed_z), .seed_w(seed_w), .seed_x(seed_x), .seed_c(seed_c),
    .rnd_out(rnd_out), .rnd_valid(rnd_valid));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_defaults();
    mz = 32'd362436069; mw = 32'd521288629; mx = 32'd123456789; mc = 32'd380116160;
  endtask

  // advance the model, returning the expected word
  task automatic model_step(output logic [31:0] e);
    logic [31:0] t;
    mz = (mz & 32'h0000FFFF) * 32'd36969 + (mz >> 16);
    mw = (mw & 32'h0000FFFF) * 32'd18000 + (mw >> 16);
    t  = mx ^ (mx << 13);
    t  = t ^ (t >> 17);
    mx = t ^ (t << 5);
    mc = mc * 32'd69069 + 32'd1234567;
    e  = (((mz << 16) + mw) ^ mc) + mx;
  endtask

  // continuous stream of n steps, each word compared
  task automatic run_steps(input int n, input string tag);
    logic [31:0] e;
    @(negedge clk);
    step_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == n - 1) step_en = 1'b0;
      model_step(e);
      last_exp = e;
      chk(rnd_out == e, tag, rnd_out, e);
      chk(rnd_valid == 1'b1, {tag, " R7 valid"}, 32'(rnd_valid), 32'd1);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    model_defaults();
    chk(rnd_valid == 1'b0, "R1 valid in reset", 32'(rnd_valid), 32'd0);
    chk(rnd_out == 32'd0, "R1 out in reset", rnd_out, 32'd0);
    run_steps(1, "R1 first word");
  endtask

  task automatic t_default_stream();
    run_steps(4096, "R10 R2 R3 R4 R5 default");
  endtask

  task automatic t_hold();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(rnd_valid == 1'b0, "R6 idle valid", 32'(rnd_valid), 32'd0);
      chk(rnd_out == last_exp, "R6 idle out", rnd_out, last_exp);
    end
    run_steps(3, "R6 resume");
  endtask

  task automatic t_gaps();
    logic [31:0] e;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); step_en = 1'b1;
      @(negedge clk); step_en = 1'b0;
      model_step(e);
      last_exp = e;
      chk(rnd_valid == 1'b1, "R7 pulse high", 32'(rnd_valid), 32'd1);
      chk(rnd_out == e, "R7 R5 gap word", rnd_out, e);
      @(negedge clk);
      chk(rnd_valid == 1'b0, "R7 pulse low", 32'(rnd_valid), 32'd0);
      @(negedge clk);
      chk(rnd_valid == 1'b0, "R7 pulse low2", 32'(rnd_valid), 32'd0);
    end
  endtask

  task automatic t_seed(input logic [31:0] z, input logic [31:0] w, input logic [31:0] x,
                        input logic [31:0] c, input bit with_step, input string tag);
    @(negedge clk);
    seed_load = 1'b1; step_en = with_step;
    seed_z = z; seed_w = w; seed_x = x; seed_c = c;
    @(negedge clk);
    seed_load = 1'b0; step_en = 1'b0;
    mz = z; mw = w; mx = (x == 32'd0) ? 32'd123456789 : x; mc = c;
    chk(rnd_valid == 1'b0, "R8 no valid on load", 32'(rnd_valid), 32'd0);
    chk(rnd_out == last_exp, "R8 out kept on load", rnd_out, last_exp);
    run_steps(8, tag);
  endtask

  initial begin
    t_reset();
    t_default_stream();
    t_hold();
    t_gaps();
    // MWC lanes at zero stay zero: exposes xorshift and congruential lanes
    t_seed(32'd0, 32'd0, 32'h2545F491, 32'd0, 1'b0, "R3 R4 mwc-zero");
    t_seed(32'h12345678, 32'h9ABCDEF0, 32'hDEADBEEF, 32'hCAFEF00D, 1'b0, "R2 R5 R8 seeded");
    t_seed(32'hFFFFFFFF, 32'h0000FFFF, 32'h80000000, 32'hFFFFFFFF, 1'b1, "R8 load priority");
    t_seed(32'h00010001, 32'h7FFF8000, 32'd0, 32'd1, 1'b0, "R9 zero xs seed");
    // reset mid-sequence returns to the default start
    t_reset();
    run_steps(16, "R1 R10 after re-reset");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule